// File: doc/BRIEF.md
# Mixed-Radix Residue-to-Binary Decoder

This block turns a residue-number-system value over the fixed, pairwise-coprime modulus set {8, 5, 7, 3} into its plain binary magnitude. The four moduli multiply to 840, so every input tuple names exactly one integer in [0, 840). The block also gives a two's-complement reading of the same value, with the range split at 420.

The conversion runs as a chain of pipeline stages. The first partial value is the modulo-8 residue itself. Each later stage works on one modulus. It reduces the running partial value by that modulus and subtracts the result from the stage's own residue, modulo that modulus. A small case-statement table maps the difference to the stage's mixed-radix digit. The digit, scaled by the product of all earlier moduli, is added to the running value.

The pipeline takes one tuple per clock. A valid strobe travels alongside the data, and a result leaves the pipeline four clock edges after its tuple is sampled.

Top module: `rns_mixed_radix_decoder`

## Requirements
- R1: When out_valid is high, out_value is the unique X in [0, 840) with X mod 8 = res_m8, X mod 5 = res_m5, X mod 7 = res_m7 and X mod 3 = res_m3. The residues are those of the tuple that was sampled with in_valid high four rising edges earlier.
- R2: A tuple sampled with in_valid high at a rising edge produces out_valid high after the fourth rising edge that follows, counting the sampling edge as the first. out_valid stays low after the three edges before that.
- R3: When out_valid is high, out_value is always below 840.
- R4: out_signed equals out_value when out_value < 420, and out_value - 840 otherwise. It is an 11-bit two's-complement number.
- R5: While rst_n is low, out_valid and out_value are 0 from the first rising edge on. After release, out_valid stays low until a new valid tuple has gone through the pipeline.
- R6: A new tuple may be presented on every clock. The pattern of in_valid highs and lows comes out on out_valid unchanged, shifted by four edges, and each result lines up with its own tuple.
- R7: Residue inputs sampled while in_valid is low never produce out_valid high and do not disturb the results of valid tuples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the residue tuple this cycle |
| res_m8 | input | 3 | Residue modulo 8 |
| res_m5 | input | 3 | Residue modulo 5, range 0..4 |
| res_m7 | input | 3 | Residue modulo 7, range 0..6 |
| res_m3 | input | 2 | Residue modulo 3, range 0..2 |
| out_valid | output | 1 | out_value and out_signed hold a result |
| out_value | output | 10 | Unsigned magnitude, 0..839 |
| out_signed | output | 11 | Signed reading, -420..419 |

## Verification
The hardest cases to reach are the ones where a stage's residue is smaller than the partial value reduced by that stage's modulus. The stage must then wrap when it subtracts. Each of the three stages has its own wrap cases, and they only appear for particular combinations of earlier residues.

The stimulus therefore streams all 840 tuples back to back, which reaches every table entry under every reachable partial value. A second pass mixes valid tuples with idle cycles that carry out-of-range residue data, to check that alignment holds. A reset is applied with the pipeline full, to check that the results in flight are dropped.

// File: rtl/rns_mixed_radix_decoder.sv
module rns_mixed_radix_decoder (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         res_m8,
  input  logic [2:0]         res_m5,
  input  logic [2:0]         res_m7,
  input  logic [1:0]         res_m3,
  output logic               out_valid,
  output logic [9:0]         out_value,
  output logic signed [10:0] out_signed
);

  localparam int unsigned RANGE = 840;
  localparam int unsigned HALF  = RANGE / 2;

  // digit tables: difference -> coefficient, using the inverse of the running weight
  function automatic logic [2:0] digit_m5(input logic [2:0] d);
    case (d)
      3'd0: digit_m5 = 3'd0;
      3'd1: digit_m5 = 3'd2;
      3'd2: digit_m5 = 3'd4;
      3'd3: digit_m5 = 3'd1;
      3'd4: digit_m5 = 3'd3;
      default: digit_m5 = 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] digit_m7(input logic [2:0] d);
    case (d)
      3'd0: digit_m7 = 3'd0;
      3'd1: digit_m7 = 3'd3;
      3'd2: digit_m7 = 3'd6;
      3'd3: digit_m7 = 3'd2;
      3'd4: digit_m7 = 3'd5;
      3'd5: digit_m7 = 3'd1;
      3'd6: digit_m7 = 3'd4;
      default: digit_m7 = 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] digit_m3(input logic [1:0] d);
    case (d)
      2'd0: digit_m3 = 2'd0;
      2'd1: digit_m3 = 2'd1;
      2'd2: digit_m3 = 2'd2;
      default: digit_m3 = 2'd0;
    endcase
  endfunction

  // input register
  logic       v0;
  logic [2:0] x1, r5_0, r7_0;
  logic [1:0] r3_0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0 <= 1'b0; x1 <= '0; r5_0 <= '0; r7_0 <= '0; r3_0 <= '0;
    end else begin
      v0 <= in_valid; x1 <= res_m8; r5_0 <= res_m5; r7_0 <= res_m7; r3_0 <= res_m3;
    end
  end

  // stage for modulus 5, weight 8
  logic [2:0] xm5, d5, a2;
  logic [5:0] x2_n;
  assign xm5  = x1 % 3'd5;
  assign d5   = (r5_0 >= xm5) ? r5_0 - xm5 : r5_0 + 3'd5 - xm5;
  assign a2   = digit_m5(d5);
  assign x2_n = {3'b000, x1} + {a2, 3'b000};

  logic       v1;
  logic [5:0] x2;
  logic [2:0] r7_1;
  logic [1:0] r3_1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; x2 <= '0; r7_1 <= '0; r3_1 <= '0;
    end else begin
      v1 <= v0; x2 <= x2_n; r7_1 <= r7_0; r3_1 <= r3_0;
    end
  end

  // stage for modulus 7, weight 40
  logic [2:0] xm7, d7, a3;
  logic [8:0] x3_n;
  assign xm7  = 3'(x2 % 6'd7);
  assign d7   = (r7_1 >= xm7) ? r7_1 - xm7 : r7_1 + 3'd7 - xm7;
  assign a3   = digit_m7(d7);
  assign x3_n = 9'(x2) + 9'(a3) * 9'd40;

  logic       v2;
  logic [8:0] x3;
  logic [1:0] r3_2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; x3 <= '0; r3_2 <= '0;
    end else begin
      v2 <= v1; x3 <= x3_n; r3_2 <= r3_1;
    end
  end

  // stage for modulus 3, weight 280
  logic [1:0] xm3, d3, a4;
  logic [9:0] x4_n;
  assign xm3  = 2'(x3 % 9'd3);
  assign d3   = (r3_2 >= xm3) ? r3_2 - xm3 : r3_2 + 2'd3 - xm3;
  assign a4   = digit_m3(d3);
  assign x4_n = 10'(x3) + 10'(a4) * 10'd280;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_value <= '0;
    end else begin
      out_valid <= v2; out_value <= x4_n;
    end
  end

  assign out_signed = (out_value < 10'(HALF)) ? $signed({1'b0, out_value})
                                              : $signed({1'b0, out_value}) - 11'(RANGE);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));

  assert_mod8_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_value[2:0] == $past(res_m8, 4)));

  assert_mod3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (2'(out_value % 10'd3) == $past(res_m3, 4)));

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_value < 10'(RANGE)));

  assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_signed[10] == (out_value >= 10'(HALF))));

endmodule

// File: tb/rns_mixed_radix_decoder_test.sv
module rns_mixed_radix_decoder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] res_m8 = '0, res_m5 = '0, res_m7 = '0;
  logic [1:0] res_m3 = '0;
  logic out_valid;
  logic [9:0] out_value;
  logic signed [10:0] out_signed;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rns_mixed_radix_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .res_m8(res_m8), .res_m5(res_m5), .res_m7(res_m7), .res_m3(res_m3),
    .out_valid(out_valid), .out_value(out_value), .out_signed(out_signed)
  );

  // {value, r8, r5, r7, r3}
  localparam logic [20:0] VEC [8] = '{
    {10'd0,   3'd0, 3'd0, 3'd0, 2'd0},
    {10'd1,   3'd1, 3'd1, 3'd1, 2'd1},
    {10'd40,  3'd0, 3'd0, 3'd5, 2'd1},
    {10'd123, 3'd3, 3'd3, 3'd4, 2'd0},
    {10'd280, 3'd0, 3'd0, 3'd0, 2'd1},
    {10'd419, 3'd3, 3'd4, 3'd6, 2'd2},
    {10'd420, 3'd4, 3'd0, 3'd0, 2'd0},
    {10'd839, 3'd7, 3'd4, 3'd6, 2'd2}
  };

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(input bit v, input int x);
    in_valid = v;
    res_m8 = 3'(x % 8);
    res_m5 = 3'(x % 5);
    res_m7 = 3'(x % 7);
    res_m3 = 2'(x % 3);
  endtask

  function automatic int signed_of(input int x);
    return (x < 420) ? x : x - 840;
  endfunction

  function automatic int gap_val(input int i);
    return (i * 13 + 100) % 840;
  endfunction

  function automatic bit gap_vld(input int i);
    return (i % 4) != 1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset valid", int'(out_valid), 0);
    check("R5 reset value", int'(out_value), 0);
    rst_n = 1'b1;

    // table vectors, one at a time
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      res_m8 = VEC[k][10:8]; res_m5 = VEC[k][7:5]; res_m7 = VEC[k][4:2]; res_m3 = VEC[k][1:0];
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check("R2 not early", int'(out_valid), 0);
      @(negedge clk);
      check("R2 valid at latency", int'(out_valid), 1);
      check("R1 vector value", int'(out_value), int'(VEC[k][20:11]));
      check("R4 vector signed", int'(out_signed), signed_of(int'(VEC[k][20:11])));
      @(negedge clk);
      check("R2 single pulse", int'(out_valid), 0);
    end

    // full back-to-back sweep
    for (int i = 0; i < 844; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        check("R6 stream valid", int'(out_valid), 1);
        check("R1 stream value", int'(out_value), i - 4);
        check("R3 stream range", int'(out_value < 10'd840), 1);
        check("R4 stream signed", int'(out_signed), signed_of(i - 4));
      end
      if (i < 840) drive(1'b1, i);
      else drive(1'b0, 0);
    end

    // gapped stream with junk on idle cycles
    for (int i = 0; i < 68; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        check("R6 R7 gap valid", int'(out_valid), int'(gap_vld(i - 4)));
        if (gap_vld(i - 4)) check("R7 gap value", int'(out_value), gap_val(i - 4));
      end
      if (i < 64 && gap_vld(i)) drive(1'b1, gap_val(i));
      else begin
        in_valid = 1'b0; res_m8 = 3'd7; res_m5 = 3'd7; res_m7 = 3'd7; res_m3 = 2'd3;
      end
    end

    // reset with a full pipeline
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      drive(1'b1, 500 + i);
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 mid reset valid", int'(out_valid), 0);
    check("R5 mid reset value", int'(out_value), 0);
    drive(1'b0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R5 flushed after reset", int'(out_valid), 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule